// File: doc/BRIEF.md
# Configurable GPIO Controller with Interrupts

A bank of twelve general purpose pins controlled through a small register window. Each pin works as an input, a push-pull output or an open-drain output. The pad side gets a value and an output enable per pin. Pin levels pass through a two-flop synchroniser. The synchronised levels feed the data readback and a level-triggered interrupt with per-pin polarity and enable. All per-pin interrupts are combined into one interrupt line.

The low eight pins can be handed to an LED alternate function. In that mode each pin drives its LED source input and ignores the GPIO settings. Strap inputs choose which pins start in LED mode, and software may change the choice later. Pins 8 and 9 also take an output-enable request from a timestamp unit, which forces them to act as outputs. The LED sources and the timestamp requests come in as plain ports.

The host interface is a write strobe, a 3-bit word offset and 16-bit write data. Register writes take effect at the next clock edge. Read data is combinational from the offset. Unused read bits return 0.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction register (offset 0, bit n = 1 makes pin n an output), the polarity register (offset 3) and the interrupt-enable register (offset 4) read 0. Every pin outside LED mode has its output enable low, and irq_o is low.
- R2: A pin with direction 1, buffer-type bit 0 (offset 2, 1 = open-drain) and not in LED mode has its output enable high. It drives the bit written to the data register (offset 1).
- R3: A pin with direction 1, buffer-type bit 1 and not in LED mode drives 0. Its output enable is high when its data bit is 0 and low when its data bit is 1.
- R4: Reading offset 1 returns, for each pin, the written data bit if the pin is an output not in LED mode. Otherwise it returns the pin level delayed by two clock edges through the synchroniser.
- R5: Bit k of ts_oe_i makes pin 8+k an output driven from its data bit even while its direction bit is 0. Pin readback then returns the data bit. No other pin is affected.
- R6: The LED-enable register (offset 6, bits 7:0) takes the value of led_strap_i during reset. A pin with its LED-enable bit set has its output enable high and drives led_src_i for that pin, whatever its direction, data and buffer bits are.
- R7: The LED-enable register is writable after reset. Clearing a bit returns that pin to its GPIO settings.
- R8: Interrupt status bit n (offset 5) becomes 1 one edge after the synchronised level of pin n equals its polarity bit (0 = low, 1 = high) while its enable bit is 1. A pin whose enable bit is 0 never sets its status bit.
- R9: Writing 1 to a status bit clears it. The bit is set again by that same write if the level condition still holds. Writing 0 leaves it unchanged. Without a clearing write, a status bit stays set after the level condition ends.
- R10: irq_o is high exactly when some status bit is 1 and its enable bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pad_in_i | input | 12 | Pin levels from the pads |
| pad_out_o | output | 12 | Value driven to each pad |
| pad_oe_o | output | 12 | Output enable to each pad |
| led_strap_i | input | 8 | LED-mode straps, loaded during reset |
| led_src_i | input | 8 | LED status sources for pins 7:0 |
| ts_oe_i | input | 2 | Timestamp output-enable requests for pins 9:8 |
| irq_o | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the pad drive rules against the register state:
- inputs never drive;
- push-pull pins follow their data;
- open-drain pins never drive high;
- LED pins follow their sources.

They also check that an enabled matching level sets its status bit at the next edge, that status bits never drop without a clearing write, and that the interrupt stays low when no enabled status is set.

The bench scenarios show the rest:
- the strap load at reset;
- the exact two-edge synchroniser latency on readback;
- the timestamp override confined to pins 8 and 9;
- the re-assertion of a status bit that is cleared while its level still holds.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_DATA = 3'd1,
    REG_BUF  = 3'd2,
    REG_POL  = 3'd3,
    REG_IEN  = 3'd4,
    REG_STS  = 3'd5,
    REG_LED  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_LED  = 8,
  parameter int unsigned TS_LO  = 8,
  parameter int unsigned N_TS   = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_LED-1:0]  led_strap_i,
  input  logic [N_TS-1:0]   ts_oe_i,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] sts_i,
  output logic [N_PINS-1:0] dir_eff_o,
  output logic [N_PINS-1:0] dout_o,
  output logic [N_PINS-1:0] od_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_LED-1:0]  led_en_o,
  output logic [N_PINS-1:0] led_mask_o,
  output logic [N_PINS-1:0] sts_clr_o
);
  localparam int unsigned PAD_W = N_PINS - N_LED;

  logic [N_PINS-1:0] dir_q, dout_q, od_q, pol_q, ien_q;
  logic [N_LED-1:0]  led_q;
  logic [N_PINS-1:0] wpins;
  logic [N_PINS-1:0] rd_pins;
  logic              unused_wdata;

  assign wpins        = wdata_i[N_PINS-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:N_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dout_q <= '0;
      od_q   <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      led_q  <= led_strap_i;
    end else if (wr_en_i) begin
      case (reg_addr_e'(addr_i))
        REG_DIR:  dir_q  <= wpins;
        REG_DATA: dout_q <= wpins;
        REG_BUF:  od_q   <= wpins;
        REG_POL:  pol_q  <= wpins;
        REG_IEN:  ien_q  <= wpins;
        REG_LED:  led_q  <= wdata_i[N_LED-1:0];
        default: ;
      endcase
    end
  end

  // timestamp requests widen the direction of their pins only
  for (genvar i = 0; i < N_PINS; i++) begin : g_dir
    if (i >= TS_LO && i < TS_LO + N_TS) begin : g_ts
      assign dir_eff_o[i] = dir_q[i] | ts_oe_i[i-TS_LO];
    end else begin : g_plain
      assign dir_eff_o[i] = dir_q[i];
    end
  end

  assign led_mask_o = {{PAD_W{1'b0}}, led_q};
  assign rd_pins    = (dir_eff_o & ~led_mask_o & dout_q) | (~(dir_eff_o & ~led_mask_o) & lvl_i);
  assign sts_clr_o  = (wr_en_i && reg_addr_e'(addr_i) == REG_STS) ? wpins : '0;

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      REG_DIR:  rdata_o[N_PINS-1:0] = dir_q;
      REG_DATA: rdata_o[N_PINS-1:0] = rd_pins;
      REG_BUF:  rdata_o[N_PINS-1:0] = od_q;
      REG_POL:  rdata_o[N_PINS-1:0] = pol_q;
      REG_IEN:  rdata_o[N_PINS-1:0] = ien_q;
      REG_STS:  rdata_o[N_PINS-1:0] = sts_i;
      REG_LED:  rdata_o[N_LED-1:0]  = led_q;
      default:  rdata_o = '0;
    endcase
  end

  assign dout_o   = dout_q;
  assign od_o     = od_q;
  assign pol_o    = pol_q;
  assign ien_o    = ien_q;
  assign led_en_o = led_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] ien_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] sts_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] sts_q, hit;

  assign hit = ien_i & ~(lvl_i ^ pol_i);

  // clear first, then a still-true condition re-sets in the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | hit;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_i);
endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad #(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_LED  = 8
) (
  input  logic [N_PINS-1:0] dir_eff_i,
  input  logic [N_PINS-1:0] dout_i,
  input  logic [N_PINS-1:0] od_i,
  input  logic [N_LED-1:0]  led_en_i,
  input  logic [N_LED-1:0]  led_src_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic led_on, led_val, p_out, p_oe;

    if (i < N_LED) begin : g_led
      assign led_on  = led_en_i[i];
      assign led_val = led_src_i[i];
    end else begin : g_noled
      assign led_on  = 1'b0;
      assign led_val = 1'b0;
    end

    always_comb begin
      if (led_on) begin
        p_out = led_val;
        p_oe  = 1'b1;
      end else if (dir_eff_i[i]) begin
        if (od_i[i]) begin
          p_out = 1'b0;
          p_oe  = ~dout_i[i];
        end else begin
          p_out = dout_i[i];
          p_oe  = 1'b1;
        end
      end else begin
        p_out = 1'b0;
        p_oe  = 1'b0;
      end
    end

    assign pad_out_o[i] = p_out;
    assign pad_oe_o[i]  = p_oe;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_LED  = 8,
  parameter int unsigned TS_LO  = 8,
  parameter int unsigned N_TS   = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  input  logic [N_LED-1:0]  led_strap_i,
  input  logic [N_LED-1:0]  led_src_i,
  input  logic [N_TS-1:0]   ts_oe_i,
  output logic              irq_o
);
  logic [N_PINS-1:0] lvl, dir_eff, dout, od, pol, ien, sts, sts_clr, led_mask;
  logic [N_LED-1:0]  led_en;

  gpio_bank_sync #(.W(N_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl)
  );

  gpio_bank_regs #(
    .N_PINS(N_PINS), .N_LED(N_LED), .TS_LO(TS_LO), .N_TS(N_TS), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .led_strap_i(led_strap_i),
    .ts_oe_i    (ts_oe_i),
    .lvl_i      (lvl),
    .sts_i      (sts),
    .dir_eff_o  (dir_eff),
    .dout_o     (dout),
    .od_o       (od),
    .pol_o      (pol),
    .ien_o      (ien),
    .led_en_o   (led_en),
    .led_mask_o (led_mask),
    .sts_clr_o  (sts_clr)
  );

  gpio_bank_irq #(.N_PINS(N_PINS)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .pol_i (pol),
    .ien_i (ien),
    .clr_i (sts_clr),
    .sts_o (sts),
    .irq_o (irq_o)
  );

  gpio_bank_pad #(.N_PINS(N_PINS), .N_LED(N_LED)) u_pad (
    .dir_eff_i(dir_eff),
    .dout_i   (dout),
    .od_i     (od),
    .led_en_i (led_en),
    .led_src_i(led_src_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_LED  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] pad_out_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic [N_LED-1:0]  led_src_i,
  input logic              irq_o,
  input logic [N_PINS-1:0] dir_eff,
  input logic [N_PINS-1:0] dout,
  input logic [N_PINS-1:0] od,
  input logic [N_PINS-1:0] led_mask,
  input logic [N_PINS-1:0] pol,
  input logic [N_PINS-1:0] ien,
  input logic [N_PINS-1:0] sts,
  input logic [N_PINS-1:0] lvl
);
  logic [N_PINS-1:0] in_m, pp_m, od_m, src_full, cond;
  logic              sts_wr;

  assign in_m     = ~dir_eff & ~led_mask;
  assign pp_m     = dir_eff & ~od & ~led_mask;
  assign od_m     = dir_eff & od & ~led_mask;
  assign src_full = {{(N_PINS-N_LED){1'b0}}, led_src_i};
  assign cond     = ien & ~(lvl ^ pol);
  assign sts_wr   = wr_en_i && reg_addr_e'(addr_i) == REG_STS;

  AST_INPUT_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & in_m) == '0);  // R1

  AST_PP_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & pp_m) == pp_m) && ((pad_out_o & pp_m) == (dout & pp_m)));  // R2

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o & od_m) == '0) && ((pad_oe_o & od_m) == (~dout & od_m)));  // R3

  AST_LED_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & led_mask) == led_mask) && ((pad_out_o & led_mask) == (src_full & led_mask)));  // R6

  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond != '0) |=> ((sts & $past(cond)) == $past(cond)));  // R8

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts)));  // R9

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts & ien) == '0) |-> !irq_o);  // R10
endmodule

bind gpio_bank gpio_bank_chk #(.N_PINS(N_PINS), .N_LED(N_LED)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .led_src_i(led_src_i),
  .irq_o    (irq_o),
  .dir_eff  (dir_eff),
  .dout     (dout),
  .od       (od),
  .led_mask (led_mask),
  .pol      (pol),
  .ien      (ien),
  .sts      (sts),
  .lvl      (lvl)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [11:0] pad_in_i = 12'hFFF;
  logic [11:0] pad_out_o, pad_oe_o;
  logic [7:0]  led_strap_i = 8'h0F;
  logic [7:0]  led_src_i = 8'hA5;
  logic [1:0]  ts_oe_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_DIR = 3'd0, A_DATA = 3'd1, A_BUF = 3'd2, A_POL = 3'd3,
                         A_IEN = 3'd4, A_STS = 3'd5, A_LED = 3'd6;

  always #5 clk_i = ~clk_i;

  gpio_bank dut (.*);

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_DIR, v); chk("R1", "dir after reset", v, 16'h0);
    rd(A_POL, v); chk("R1", "pol after reset", v, 16'h0);
    rd(A_IEN, v); chk("R1", "ien after reset", v, 16'h0);
    chk("R1", "irq after reset", {15'b0, irq_o}, 16'h0);
    rd(A_LED, v); chk("R6", "led enable from straps", v, 16'h000F);
    chk("R6", "oe of strapped led pins", {4'b0, pad_oe_o}, 16'h000F);
    chk("R6", "led pin values", {4'b0, pad_out_o & 12'h00F}, 16'h0005);
    wr(A_LED, 16'h0000);
    chk("R7", "led release oe", {4'b0, pad_oe_o}, 16'h0000);
  endtask

  task automatic t_pushpull_readback();
    logic [15:0] v;
    pad_in_i = 12'h03C;
    wr(A_DIR, 16'h0F00);
    wr(A_BUF, 16'h0000);
    wr(A_DATA, 16'h0A00);
    chk("R2", "push-pull oe", {4'b0, pad_oe_o}, 16'h0F00);
    chk("R2", "push-pull out", {4'b0, pad_out_o}, 16'h0A00);
    settle();
    rd(A_DATA, v); chk("R4", "mixed readback", v, 16'h0A3C);
    pad_in_i = 12'h0C3;
    @(negedge clk_i); #1;
    rd(A_DATA, v); chk("R4", "readback after one edge", v, 16'h0A3C);
    @(negedge clk_i); #1;
    rd(A_DATA, v); chk("R4", "readback after two edges", v, 16'h0AC3);
  endtask

  task automatic t_opendrain();
    wr(A_DIR, 16'h00F0);
    wr(A_BUF, 16'h00F0);
    wr(A_DATA, 16'h0050);
    chk("R3", "open-drain oe", {4'b0, pad_oe_o}, 16'h00A0);
    chk("R3", "open-drain out", {4'b0, pad_out_o}, 16'h0000);
    wr(A_BUF, 16'h0000);
    chk("R2", "back to push-pull oe", {4'b0, pad_oe_o}, 16'h00F0);
    chk("R2", "back to push-pull out", {4'b0, pad_out_o}, 16'h0050);
  endtask

  task automatic t_ts();
    logic [15:0] v;
    wr(A_DIR, 16'h0000);
    wr(A_DATA, 16'h0300);
    pad_in_i = 12'h000;
    settle();
    ts_oe_i = 2'b01; #1;
    chk("R5", "ts pin8 oe", {4'b0, pad_oe_o}, 16'h0100);
    chk("R5", "ts pin8 out", {4'b0, pad_out_o}, 16'h0100);
    rd(A_DATA, v); chk("R5", "ts pin8 readback", v, 16'h0100);
    ts_oe_i = 2'b10; #1;
    chk("R5", "ts pin9 oe", {4'b0, pad_oe_o}, 16'h0200);
    ts_oe_i = 2'b00; #1;
    chk("R5", "ts release", {4'b0, pad_oe_o}, 16'h0000);
  endtask

  task automatic t_led();
    logic [15:0] v;
    led_src_i = 8'h80;
    wr(A_DIR, 16'h0FFF);
    wr(A_DATA, 16'h0000);
    wr(A_LED, 16'h0081);
    rd(A_LED, v); chk("R7", "led enable written", v, 16'h0081);
    chk("R6", "led overrides gpio oe", {4'b0, pad_oe_o}, 16'h0FFF);
    chk("R6", "led overrides gpio out", {4'b0, pad_out_o}, 16'h0080);
    wr(A_LED, 16'h0000);
    chk("R7", "gpio data after led off", {4'b0, pad_out_o}, 16'h0000);
    wr(A_DIR, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    pad_in_i = 12'hFFF;
    wr(A_POL, 16'h0000);
    wr(A_IEN, 16'h0001);
    settle();
    rd(A_STS, v); chk("R8", "no match no status", v, 16'h0000);
    chk("R10", "irq idle", {15'b0, irq_o}, 16'h0);
    pad_in_i = 12'hFFC;
    settle();
    rd(A_STS, v); chk("R8", "low level sets only enabled pin", v, 16'h0001);
    chk("R10", "irq raised", {15'b0, irq_o}, 16'h1);
    wr(A_STS, 16'h0001);
    rd(A_STS, v); chk("R9", "clear while held re-sets", v, 16'h0001);
    pad_in_i = 12'hFFF;
    settle();
    rd(A_STS, v); chk("R9", "sticky after level ends", v, 16'h0001);
    wr(A_STS, 16'h0000);
    rd(A_STS, v); chk("R9", "write 0 no effect", v, 16'h0001);
    wr(A_STS, 16'h0001);
    rd(A_STS, v); chk("R9", "write 1 clears", v, 16'h0000);
    chk("R10", "irq dropped", {15'b0, irq_o}, 16'h0);
    wr(A_POL, 16'h0002);
    wr(A_IEN, 16'h0002);
    settle();
    rd(A_STS, v); chk("R8", "high polarity sets", v, 16'h0002);
    chk("R10", "irq high polarity", {15'b0, irq_o}, 16'h1);
    wr(A_IEN, 16'h0000);
    chk("R10", "irq masked by enable", {15'b0, irq_o}, 16'h0);
    rd(A_STS, v); chk("R9", "status kept when disabled", v, 16'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_pushpull_readback();
    t_opendrain();
    t_ts();
    t_led();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule